// File: doc/BRIEF.md
# Cycle Counter Performance Monitor

This block is a memory-mapped cycle counter that sits beside a processor core. Software configures it and reads it over a simple synchronous register bus. The bus carries a select, a write strobe, a word address, write data and a privilege flag. The counter is 64 bits wide. Software reaches it as two 32-bit words, and it advances on the core clock either on every cycle or once per 64 cycles. Counting needs three things together: the global enable, the counter's own enable, and no stop request. Software uses the block to measure elapsed cycles between two reads of the count.

A control word holds the mode bits and two self-clearing reset requests. A write-one-to-set enable word holds the cycle counter's enable and the enables of four event counters. A one-bit user-access word decides whether unprivileged software may touch the block at all. A sticky overflow flag records each wrap of the counter, and software clears it by writing one. When unprivileged software accesses the block while user access is off, the access is refused: it reads zero, raises an error pulse and writes nothing.

A read returns its data one cycle after the access. The value is the register content during the access cycle. When a software write to a count word and a counter advance fall in the same cycle, the write wins and the advance is dropped.

Top module: `cyc_perf_mon`

## Requirements
- R1: After reset, every register reads zero: control at word 0, enable set at word 1, user access at word 2, count low at word 3, count high at word 4, overflow at word 5.
- R2: The count advances only while control bit 0 (global enable) is set and enable-set bit 31 (cycle counter enable) is set. Clearing bit 0 freezes the count after the cycle in which the write lands.
- R3: Writing the enable-set word sets each enable whose data bit is 1, in bit 31 and bits 3:0. A 0 bit leaves its enable as it was. Reads return the enables, and all other bits read 0.
- R4: Writing 1 to control bit 2 clears the whole count to zero. Control bit 1 is a reset request for the event counters and keeps no state. Bits 1 and 2 both read as 0, while bits 0, 3, 4, 5 and 6 read back as written.
- R5: While control bit 5 is set, the count does not advance, even with both enables set.
- R6: With control bit 3 set, the count advances once per 64 enabled cycles, and the first advance comes on the 64th cycle. The 6-bit prescaler returns to zero whenever the count is cleared or bit 3 changes value.
- R7: With control bit 6 clear, only the low word counts. It wraps from 0xFFFFFFFF to 0, and the high word is left unchanged.
- R8: With control bit 6 set, a carry out of the low word increments the high word, and the full 64-bit value wraps to zero.
- R9: A wrap (of the low word in 32-bit mode, of all 64 bits in 64-bit mode) sets overflow bit 0 at word 5. The flag stays set until software writes 1 to that bit; writing 0 leaves it set.
- R10: A write to word 3 replaces count bits 31:0 and leaves bits 63:32 unchanged. A write to word 4 replaces bits 63:32 only.
- R11: When the privilege input is low and user-access bit 0 at word 2 is clear, any access returns zero data, pulses the error output for one cycle and changes no register. When the user bit is set, unprivileged access works like privileged access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also the count clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register access in this cycle |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | 3 | Word address |
| regWdata | input | 32 | Write data |
| regPriv | input | 1 | 1 = privileged access |
| regRdata | output | 32 | Read data, valid the cycle after a read |
| regErr | output | 1 | One-cycle pulse after a refused access |

## Verification
A wrong enable or stop term shows up at the ports within one cycle, because two back-to-back reads of the low word stop differing by exactly one. A prescaler that is not cleared when the mode changes moves the first divided advance off the cycle at which the bench expects it, so a read at that cycle gives the wrong count. A carry or mode fault changes the high word or the overflow flag on the cycle right after the wrap. A leaked refused write shows up on the next privileged read of the word it hit.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_USER = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOW  = 3'd3;
  localparam logic [ADDR_W-1:0] A_HIGH = 3'd4;
  localparam logic [ADDR_W-1:0] A_OVF  = 3'd5;

  // strobes and levels passed from control to datapath
  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic clrCount;
    logic clrPre;
    logic clrOvf;
    logic countOn;
    logic div64;
    logic longMode;
  } cpmStrobe_t;
endpackage

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  cpmStrobe_t          strb,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] cnt,
  output logic                ovf
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0]  pre;
  logic [DATA_W:0]   loSum;
  logic              swWrite;
  logic              tick;
  logic              advance;
  logic              wrapEv;

  assign swWrite = strb.wrLow | strb.wrHigh;
  assign tick    = strb.countOn & (~strb.div64 | (pre == PRE_MAX));
  assign advance = tick & ~swWrite & ~strb.clrCount;
  assign loSum   = {1'b0, cnt[DATA_W-1:0]} + 1'b1;
  assign wrapEv  = advance & loSum[DATA_W] & (~strb.longMode | (&cnt[CNT_W-1:DATA_W]));

  always_ff @(posedge clk) begin
    if (!rstN) pre <= '0;
    else if (strb.clrPre) pre <= '0;
    else if (strb.countOn && strb.div64) pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (strb.clrCount) cnt <= '0;
    else if (swWrite) begin
      if (strb.wrLow)  cnt[DATA_W-1:0]     <= wdata;
      if (strb.wrHigh) cnt[CNT_W-1:DATA_W] <= wdata;
    end else if (advance) begin
      cnt[DATA_W-1:0] <= loSum[DATA_W-1:0];
      if (strb.longMode && loSum[DATA_W])
        cnt[CNT_W-1:DATA_W] <= cnt[CNT_W-1:DATA_W] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ovf <= 1'b0;
    else if (wrapEv) ovf <= 1'b1;
    else if (strb.clrOvf) ovf <= 1'b0;
  end

  // R2 R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countOn && !swWrite && !strb.clrCount) |=> $stable(cnt));
  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCount |=> (cnt == '0));
  // R6
  prescale_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.div64 && pre != PRE_MAX && !swWrite && !strb.clrCount) |=> $stable(cnt));
  // R7
  narrow_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.longMode && !strb.wrHigh && !strb.clrCount) |=> $stable(cnt[CNT_W-1:DATA_W]));
  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovf) |-> $past(strb.countOn));
endmodule

// File: rtl/cpm_ctrl.sv
module cpm_ctrl
  import cpm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_N  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regSel,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  input  logic                regPriv,
  input  logic [2*DATA_W-1:0] cnt,
  input  logic                ovf,
  output cpmStrobe_t          strb,
  output logic [DATA_W-1:0]   regRdata,
  output logic                regErr
);
  logic             enReg, divReg, auxReg, stopReg, longReg, userEn;
  logic [EVT_N:0]   cenReg;   // top bit: cycle counter
  logic             granted, denied, wrOk;
  logic [DATA_W-1:0] rdMux, cenView, ctrlView;
  logic             unusedBits;

  assign granted    = regSel & (regPriv | userEn);
  assign denied     = regSel & ~regPriv & ~userEn;
  assign wrOk       = granted & regWr;
  assign unusedBits = &{1'b0, regWdata[DATA_W-2:7]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= 1'b0; divReg <= 1'b0; auxReg <= 1'b0;
      stopReg <= 1'b0; longReg <= 1'b0; userEn <= 1'b0;
      cenReg <= '0;
    end else if (wrOk) begin
      case (regAddr)
        A_CTRL: begin
          enReg   <= regWdata[0];
          divReg  <= regWdata[3];
          auxReg  <= regWdata[4];
          stopReg <= regWdata[5];
          longReg <= regWdata[6];
        end
        A_CEN:  cenReg <= cenReg | {regWdata[DATA_W-1], regWdata[EVT_N-1:0]};
        A_USER: userEn <= regWdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrLow    = wrOk & (regAddr == A_LOW);
    strb.wrHigh   = wrOk & (regAddr == A_HIGH);
    strb.clrCount = wrOk & (regAddr == A_CTRL) & regWdata[2];
    strb.clrPre   = strb.clrCount | (wrOk & (regAddr == A_CTRL) & (regWdata[3] != divReg));
    strb.clrOvf   = wrOk & (regAddr == A_OVF) & regWdata[0];
    strb.countOn  = enReg & cenReg[EVT_N] & ~stopReg;
    strb.div64    = divReg;
    strb.longMode = longReg;
  end

  always_comb begin
    cenView = '0;
    cenView[DATA_W-1] = cenReg[EVT_N];
    for (int i = 0; i < EVT_N; i++) cenView[i] = cenReg[i];
    ctrlView = '0;
    ctrlView[0] = enReg;
    ctrlView[3] = divReg;
    ctrlView[4] = auxReg;
    ctrlView[5] = stopReg;
    ctrlView[6] = longReg;
    case (regAddr)
      A_CTRL:  rdMux = ctrlView;
      A_CEN:   rdMux = cenView;
      A_USER:  rdMux = {{(DATA_W-1){1'b0}}, userEn};
      A_LOW:   rdMux = cnt[DATA_W-1:0];
      A_HIGH:  rdMux = cnt[2*DATA_W-1:DATA_W];
      A_OVF:   rdMux = {{(DATA_W-1){1'b0}}, ovf};
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
      regErr   <= 1'b0;
    end else begin
      regRdata <= (granted && !regWr) ? rdMux : '0;
      regErr   <= denied;
    end
  end

  // R11
  deny_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    denied |=> (regErr && regRdata == '0));
  // R11
  deny_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (denied && regWr) |=> $stable({enReg, divReg, auxReg, stopReg, longReg, userEn, cenReg}));
  // R3
  cen_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((cenReg & $past(cenReg)) == $past(cenReg)));
endmodule

// File: rtl/cyc_perf_mon.sv
module cyc_perf_mon
  import cpm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EVT_N  = 4,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regPriv,
  output logic [DATA_W-1:0] regRdata,
  output logic              regErr
);
  cpmStrobe_t          strb;
  logic [2*DATA_W-1:0] cnt;
  logic                ovf;

  cpm_ctrl #(.DATA_W(DATA_W), .EVT_N(EVT_N)) uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regPriv(regPriv),
    .cnt(cnt), .ovf(ovf), .strb(strb),
    .regRdata(regRdata), .regErr(regErr)
  );

  cpm_datapath #(.DATA_W(DATA_W), .PRE_W(PRE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(regWdata),
    .cnt(cnt), .ovf(ovf)
  );
endmodule

// File: tb/sim_cyc_perf_mon.sv
`timescale 1ns/1ps
module sim_cyc_perf_mon;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0, regWr = 1'b0, regPriv = 1'b1;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regErr;

  int tests = 0, fails = 0;
  bit reported = 0;

  typedef struct packed {
    logic [31:0] data;
    logic        chkData;
    logic        err;
    logic [7:0]  req;
  } item_t;
  item_t sbq[$];

  localparam logic [2:0] CTRL = 3'd0, CEN = 3'd1, USR = 3'd2,
                         LOW = 3'd3, HIGH = 3'd4, OVF = 3'd5;

  always #2.5 clk = ~clk;

  cyc_perf_mon u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regPriv(regPriv),
    .regRdata(regRdata), .regErr(regErr)
  );

  // monitor: pops one expectation per access, compares the response
  always @(posedge clk) begin
    if (rstN && regSel) begin
      item_t it;
      it = sbq.pop_front();
      #1;
      if (it.chkData) begin
        tests++;
        if (regRdata !== it.data) begin
          fails++;
          $display("FAIL R%0d data: got %h expected %h", it.req, regRdata, it.data);
        end
      end
      tests++;
      if (regErr !== it.err) begin
        fails++;
        $display("FAIL R%0d err: got %b expected %b", it.req, regErr, it.err);
      end
    end
  end

  task automatic acc(input logic w, input logic [2:0] a, input logic [31:0] d,
                     input logic p, input logic [31:0] expD, input logic chk,
                     input logic expE, input int req);
    @(negedge clk);
    regSel = 1'b1; regWr = w; regAddr = a; regWdata = d; regPriv = p;
    sbq.push_back('{expD, chk, expE, 8'(req)});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input int req);
    acc(1'b1, a, d, 1'b1, 32'h0, 1'b0, 1'b0, req);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input int req);
    acc(1'b0, a, 32'h0, 1'b1, e, 1'b1, 1'b0, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      regSel = 1'b0; regWr = 1'b0;
    end
  endtask

  task automatic summary;
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rd(CTRL, 0, 1); rd(CEN, 0, 1); rd(USR, 0, 1);
    rd(LOW, 0, 1); rd(HIGH, 0, 1); rd(OVF, 0, 1);
    // R2 global enable alone does not count
    wr(CTRL, 32'h5, 2); idle(3); rd(LOW, 0, 2);
    // R3 write-one-to-set enables
    wr(CEN, 32'h8000_0005, 3); rd(CEN, 32'h8000_0005, 3);
    wr(CEN, 32'h0000_0002, 3); rd(CEN, 32'h8000_0007, 3);
    // R4 reset bits self-clear, others read back
    wr(CTRL, 32'h36, 4); rd(CTRL, 32'h30, 4); rd(LOW, 0, 4);
    // R5 stop bit holds count
    wr(CTRL, 32'h21, 5); idle(4); rd(LOW, 0, 5);
    // R2 counting every cycle, then freeze
    wr(CTRL, 32'h05, 2); rd(LOW, 0, 2); rd(LOW, 1, 2); idle(10); rd(LOW, 12, 2);
    wr(CTRL, 32'h0, 2); rd(LOW, 14, 2); idle(3); rd(LOW, 14, 2);
    // R10 word writes
    wr(HIGH, 32'h1234_5678, 10); wr(LOW, 32'hAAAA_0000, 10);
    rd(HIGH, 32'h1234_5678, 10); rd(LOW, 32'hAAAA_0000, 10);
    wr(LOW, 32'h55, 10); rd(HIGH, 32'h1234_5678, 10); rd(LOW, 32'h55, 10);
    // R7 32-bit wrap, R9 overflow
    wr(LOW, 32'hFFFF_FFFD, 7); wr(HIGH, 32'h1, 7); wr(CTRL, 32'h1, 7);
    rd(LOW, 32'hFFFF_FFFD, 7); rd(LOW, 32'hFFFF_FFFE, 7); rd(LOW, 32'hFFFF_FFFF, 7);
    rd(HIGH, 32'h1, 7); rd(OVF, 1, 9);
    wr(CTRL, 32'h0, 9); wr(OVF, 32'h0, 9); rd(OVF, 1, 9);
    wr(OVF, 32'h1, 9); rd(OVF, 0, 9);
    // R8 carry into high word
    wr(HIGH, 32'h0, 8); wr(LOW, 32'hFFFF_FFFF, 8); wr(CTRL, 32'h41, 8);
    rd(LOW, 32'hFFFF_FFFF, 8); rd(HIGH, 32'h1, 8); wr(CTRL, 32'h0, 8); rd(OVF, 0, 8);
    // R8 full wrap sets R9 flag
    wr(HIGH, 32'hFFFF_FFFF, 8); wr(LOW, 32'hFFFF_FFFE, 8); wr(CTRL, 32'h41, 8);
    rd(HIGH, 32'hFFFF_FFFF, 8); rd(LOW, 32'hFFFF_FFFF, 8); rd(HIGH, 32'h0, 8);
    wr(CTRL, 32'h0, 8); rd(OVF, 1, 9); wr(OVF, 32'h1, 9);
    // R6 divide by 64
    wr(CTRL, 32'h0D, 6); idle(62);
    rd(LOW, 0, 6); rd(LOW, 0, 6); rd(LOW, 1, 6); wr(CTRL, 32'h0, 6);
    // R6 prescaler cleared when bit 3 changes
    wr(CTRL, 32'h0D, 6); idle(29); wr(CTRL, 32'h01, 6); wr(CTRL, 32'h09, 6);
    idle(60); rd(LOW, 1, 6); idle(2); rd(LOW, 1, 6); rd(LOW, 2, 6);
    wr(CTRL, 32'h0, 6);
    // R11 access gating
    wr(LOW, 32'hC3, 11);
    acc(1'b0, CTRL, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, 11);
    acc(1'b1, LOW, 32'hDEAD, 1'b0, 32'h0, 1'b0, 1'b1, 11);
    acc(1'b1, USR, 32'h1, 1'b0, 32'h0, 1'b0, 1'b1, 11);
    rd(LOW, 32'hC3, 11); rd(USR, 0, 11);
    wr(USR, 32'h1, 11);
    acc(1'b0, LOW, 32'h0, 1'b0, 32'hC3, 1'b1, 1'b0, 11);
    acc(1'b1, LOW, 32'h77, 1'b0, 32'h0, 1'b0, 1'b0, 11);
    rd(LOW, 32'h77, 11);
    idle(3);
    summary();
    $finish;
  end
endmodule